// File: doc/BRIEF.md
# Single-Issue Fetch-Execute RISC Core

This block is a small sequential processor that runs one instruction per clock. It covers a subset of a 32-bit, three-format instruction set: register-register ALU operations, register-immediate ALU operations and an unconditional jump. Instructions come from an internal word-organised program store. A testbench or loader writes that store through a simple write port. A 32-entry by 32-bit register file holds all operand state. In each step the core reads the word addressed by the program counter, advances the counter by four, and executes the word. A jump then replaces the advanced counter.

A halt input freezes the core between steps, so the program store can be loaded and the register file inspected. Any register can be read at any time through a combinational observe port. The current program counter is always visible at the top level. There is no data memory, no conditional branch and no pipelining. Every instruction completes in the clock edge that executes it.

Top module: `mini_risc_core`

## Requirements
- R1: While reset is high, each clock edge sets the program counter to 0 and clears every register to 0. The program store is not affected.
- R2: On each clock edge with reset low and halt low, the core executes the word at program-store index pc[AW+1:2]. If that word is not a jump, the program counter becomes pc+4. The counter is always a multiple of 4.
- R3: While halt is high, the program counter and all registers keep their values. Program-store writes are still accepted, and the observe port returns the register selected by the observe select input.
- R4: Opcode 0 (bits 31:26) is a register-register operation. funct (bits 5:0) selects it, rs is bits 25:21, rt is bits 20:16, and the result goes to rd (bits 15:11). funct 0x20 and 0x21 write rs+rt, and 0x22 and 0x23 write rs-rt, both modulo 2^32 with no trap.
- R5: funct 0x24, 0x25, 0x26 and 0x27 write rs AND rt, rs OR rt, rs XOR rt and NOR(rs, rt).
- R6: funct 0x2A writes 1 if rs < rt as signed values and 0 otherwise. funct 0x2B does the same comparison as unsigned values.
- R7: funct 0x00, 0x02 and 0x03 shift rt by shamt (bits 10:6): left logical, right logical and right arithmetic.
- R8: funct 0x04, 0x06 and 0x07 shift rt in the same three ways, by the low 5 bits of register rs.
- R9: Opcodes 0x08 and 0x09 write rs + sign-extended imm[15:0] to rt. Opcode 0x0A writes to rt the signed comparison rs < sext(imm), and 0x0B writes the unsigned comparison rs < sext(imm), each as 1 or 0.
- R10: Opcodes 0x0C, 0x0D and 0x0E write to rt the AND, OR and XOR of rs with the zero-extended immediate.
- R11: Opcode 0x0F writes {imm, 16'h0000} to rt.
- R12: Register 0 always reads as 0. Writes that target it have no effect.
- R13: Opcode 0x02 sets the program counter to {(pc+4)[31:28], target[25:0], 2'b00}.
- R14: An unrecognised opcode, or opcode 0 with an unrecognised funct, writes no register and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| haltReq | input | 1 | Freezes execution while high |
| loadEn | input | 1 | Program-store write strobe |
| loadAddr | input | $clog2(IMEM_DEPTH) | Program-store word index |
| loadWord | input | 32 | Instruction word to store |
| obsSel | input | 5 | Register index for the observe port |
| obsVal | output | 32 | Contents of the selected register |
| pcOut | output | 32 | Current program counter |

## Verification
The assertions check the control flow on every cycle. The counter stays word aligned, steps by four, holds still under halt, lands on the computed target after a jump and returns to zero under reset. They also check that register 0 always reads as zero and that a halted core never raises a write strobe. The results of the ALU operations can only be seen through the bench's scenarios. Those scenarios load operands through upper-immediate and OR-immediate pairs, sweep every funct and immediate opcode over signed, unsigned and boundary operand pairs, and compare the destination register with values computed arithmetically. The skipped instruction in the jump program, the writes aimed at register 0 and the undefined encodings are shown the same way, through the observe port.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } aluOp_e;

  typedef enum logic { IMM_SIGN, IMM_ZERO } immKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     step;     // execute this cycle
    logic     regWr;    // write the destination register
    logic     dstRd;    // destination is rd (else rt)
    logic     useImm;   // operand B is the immediate
    immKind_e immKind;
    aluOp_e   aluOp;
    logic     shVar;    // shift count from rs
    logic     jump;
  } ctlBus_t;
endpackage

// File: rtl/mrc_ctrl.sv
module mrc_ctrl
  import mrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       haltReq,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctlBus_t    ctl
);
  logic known;

  always_comb begin
    ctl = '0;
    known = 1'b1;
    ctl.step = !haltReq;
    unique case (opcode)
      6'h00: begin
        ctl.dstRd = 1'b1;
        case (funct)
          6'h20, 6'h21: ctl.aluOp = ALU_ADD;
          6'h22, 6'h23: ctl.aluOp = ALU_SUB;
          6'h24: ctl.aluOp = ALU_AND;
          6'h25: ctl.aluOp = ALU_OR;
          6'h26: ctl.aluOp = ALU_XOR;
          6'h27: ctl.aluOp = ALU_NOR;
          6'h2A: ctl.aluOp = ALU_SLT;
          6'h2B: ctl.aluOp = ALU_SLTU;
          6'h00: ctl.aluOp = ALU_SLL;
          6'h02: ctl.aluOp = ALU_SRL;
          6'h03: ctl.aluOp = ALU_SRA;
          6'h04: begin ctl.aluOp = ALU_SLL; ctl.shVar = 1'b1; end
          6'h06: begin ctl.aluOp = ALU_SRL; ctl.shVar = 1'b1; end
          6'h07: begin ctl.aluOp = ALU_SRA; ctl.shVar = 1'b1; end
          default: known = 1'b0;
        endcase
      end
      6'h02: begin ctl.jump = 1'b1; known = 1'b0; end
      6'h08, 6'h09: begin ctl.useImm = 1'b1; ctl.aluOp = ALU_ADD; end
      6'h0A: begin ctl.useImm = 1'b1; ctl.aluOp = ALU_SLT; end
      6'h0B: begin ctl.useImm = 1'b1; ctl.aluOp = ALU_SLTU; end
      6'h0C: begin ctl.useImm = 1'b1; ctl.immKind = IMM_ZERO; ctl.aluOp = ALU_AND; end
      6'h0D: begin ctl.useImm = 1'b1; ctl.immKind = IMM_ZERO; ctl.aluOp = ALU_OR; end
      6'h0E: begin ctl.useImm = 1'b1; ctl.immKind = IMM_ZERO; ctl.aluOp = ALU_XOR; end
      6'h0F: begin ctl.useImm = 1'b1; ctl.immKind = IMM_ZERO; ctl.aluOp = ALU_LUI; end
      default: known = 1'b0;
    endcase
    ctl.regWr = known && ctl.step;
  end

  // R3
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    haltReq |-> (!ctl.regWr));

  // R14
  undefined_op_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode inside {6'h01, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h3F}) |-> (!ctl.regWr && !ctl.jump));
endmodule

// File: rtl/mrc_regfile.sv
module mrc_regfile
  import mrc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wEn,
  input  logic [RIDX-1:0] wAddr,
  input  logic [XLEN-1:0] wData,
  input  logic [RIDX-1:0] rAddrA,
  input  logic [RIDX-1:0] rAddrB,
  input  logic [RIDX-1:0] rAddrObs,
  output logic [XLEN-1:0] rDataA,
  output logic [XLEN-1:0] rDataB,
  output logic [XLEN-1:0] rDataObs
);
  logic [XLEN-1:0] regs [NREG];

  // entry 0 is never written, so it keeps its reset value of zero
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wEn && (wAddr != '0)) begin
      regs[wAddr] <= wData;
    end
  end

  assign rDataA   = regs[rAddrA];
  assign rDataB   = regs[rAddrB];
  assign rDataObs = regs[rAddrObs];
endmodule

// File: rtl/mrc_dpath.sv
module mrc_dpath
  import mrc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  localparam int AW = $clog2(IMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctlBus_t         ctl,
  input  logic            loadEn,
  input  logic [AW-1:0]   loadAddr,
  input  logic [XLEN-1:0] loadWord,
  input  logic [RIDX-1:0] obsSel,
  output logic [XLEN-1:0] obsVal,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic [XLEN-1:0] pcOut
);
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] pcQ, pcPlus4, pcNext, instr;
  logic [XLEN-1:0] opA, opB, rtVal, immExt, aluRes;
  logic [RIDX-1:0] rsIdx, rtIdx, rdIdx, dstIdx;
  logic [4:0]      shamt, shCnt;
  logic [15:0]     imm16;
  logic [25:0]     target;

  always_ff @(posedge clk) begin
    if (loadEn) imem[loadAddr] <= loadWord;
  end

  assign instr  = imem[pcQ[AW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm16  = instr[15:0];
  assign target = instr[25:0];

  mrc_regfile u_regs (
    .clk(clk), .rst(rst),
    .wEn(ctl.regWr), .wAddr(dstIdx), .wData(aluRes),
    .rAddrA(rsIdx), .rAddrB(rtIdx), .rAddrObs(obsSel),
    .rDataA(opA), .rDataB(rtVal), .rDataObs(obsVal)
  );

  assign dstIdx = ctl.dstRd ? rdIdx : rtIdx;
  assign immExt = (ctl.immKind == IMM_SIGN) ? {{16{imm16[15]}}, imm16} : {16'h0000, imm16};
  assign opB    = ctl.useImm ? immExt : rtVal;
  assign shCnt  = ctl.shVar ? opA[4:0] : shamt;

  always_comb begin
    unique case (ctl.aluOp)
      ALU_ADD:  aluRes = opA + opB;
      ALU_SUB:  aluRes = opA - opB;
      ALU_AND:  aluRes = opA & opB;
      ALU_OR:   aluRes = opA | opB;
      ALU_XOR:  aluRes = opA ^ opB;
      ALU_NOR:  aluRes = ~(opA | opB);
      ALU_SLT:  aluRes = {31'd0, $signed(opA) < $signed(opB)};
      ALU_SLTU: aluRes = {31'd0, opA < opB};
      ALU_SLL:  aluRes = opB << shCnt;
      ALU_SRL:  aluRes = opB >> shCnt;
      ALU_SRA:  aluRes = $unsigned($signed(opB) >>> shCnt);
      ALU_LUI:  aluRes = {imm16, 16'h0000};
      default:  aluRes = '0;
    endcase
  end

  assign pcPlus4 = pcQ + 32'd4;
  assign pcNext  = ctl.jump ? {pcPlus4[31:28], target, 2'b00} : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst)           pcQ <= '0;
    else if (ctl.step) pcQ <= pcNext;
  end

  assign pcOut = pcQ;

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (pcQ == '0));

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (rst) pcQ[1:0] == 2'b00);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.step && !ctl.jump) |=> (pcQ == $past(pcQ) + 32'd4));

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.step |=> $stable(pcQ));

  // R13
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.step && ctl.jump) |=> (pcQ[27:0] == {$past(instr[25:0]), 2'b00}));
endmodule

// File: rtl/mini_risc_core.sv
module mini_risc_core
  import mrc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          haltReq,
  input  logic                          loadEn,
  input  logic [$clog2(IMEM_DEPTH)-1:0] loadAddr,
  input  logic [31:0]                   loadWord,
  input  logic [4:0]                    obsSel,
  output logic [31:0]                   obsVal,
  output logic [31:0]                   pcOut
);
  ctlBus_t    ctl;
  logic [5:0] opcode, funct;

  mrc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .haltReq(haltReq),
    .opcode(opcode), .funct(funct), .ctl(ctl)
  );

  mrc_dpath #(.IMEM_DEPTH(IMEM_DEPTH)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadWord(loadWord),
    .obsSel(obsSel), .obsVal(obsVal),
    .opcode(opcode), .funct(funct), .pcOut(pcOut)
  );

  // R12
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (obsSel == 5'd0) |-> (obsVal == 32'd0));
endmodule

// File: tb/test_mini_risc_core.sv
module test_mini_risc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        haltReq = 1'b1;
  logic        loadEn = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadWord = '0;
  logic [4:0]  obsSel = '0;
  logic [31:0] obsVal, pcOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  logic [31:0] prog [16];
  int          progLen;

  mini_risc_core i_mini_risc_core (
    .clk(clk), .rst(rst), .haltReq(haltReq), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadWord(loadWord), .obsSel(obsSel),
    .obsVal(obsVal), .pcOut(pcOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFails = nFails + 1;
      nChecks = nChecks + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] encI(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  // expected R-type result; bit 32 = destination written
  function automatic logic [32:0] modelR(int fn, logic [31:0] a, logic [31:0] b, int sh);
    case (fn)
      'h20, 'h21: return {1'b1, a + b};
      'h22, 'h23: return {1'b1, a - b};
      'h24: return {1'b1, a & b};
      'h25: return {1'b1, a | b};
      'h26: return {1'b1, a ^ b};
      'h27: return {1'b1, ~(a | b)};
      'h2A: return {1'b1, 31'd0, $signed(a) < $signed(b)};
      'h2B: return {1'b1, 31'd0, a < b};
      'h00: return {1'b1, b << sh};
      'h02: return {1'b1, b >> sh};
      'h03: return {1'b1, $unsigned($signed(b) >>> sh)};
      'h04: return {1'b1, b << a[4:0]};
      'h06: return {1'b1, b >> a[4:0]};
      'h07: return {1'b1, $unsigned($signed(b) >>> a[4:0])};
      default: return {1'b0, 32'd0};
    endcase
  endfunction

  function automatic logic [31:0] modelI(int op, logic [31:0] a, logic [15:0] imm);
    logic [31:0] s = {{16{imm[15]}}, imm};
    logic [31:0] z = {16'h0, imm};
    case (op)
      'h08, 'h09: return a + s;
      'h0A: return {31'd0, $signed(a) < $signed(s)};
      'h0B: return {31'd0, a < s};
      'h0C: return a & z;
      'h0D: return a | z;
      'h0E: return a ^ z;
      default: return {imm, 16'h0};
    endcase
  endfunction

  task automatic loadProg();
    for (int i = 0; i < progLen; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 6'(i); loadWord = prog[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runProg(input int steps);
    @(negedge clk);
    rst = 1'b1; haltReq = 1'b1;
    loadProg();
    @(negedge clk);
    rst = 1'b0;
    haltReq = 1'b0;
    repeat (steps) @(negedge clk);
    haltReq = 1'b1;
  endtask

  task automatic getReg(input int idx, output logic [31:0] v);
    obsSel = 5'(idx);
    #1;
    v = obsVal;
  endtask

  task automatic setReg(input int idx, input logic [31:0] v, input int at);
    prog[at]   = encI('h0F, 0, idx, v[31:16]);
    prog[at+1] = encI('h0D, idx, idx, v[15:0]);
  endtask

  logic [31:0] opsA [6] = '{32'h0, 32'h7, 32'hFFFFFFFF, 32'h80000000, 32'h12345678, 32'h00000025};
  logic [31:0] opsB [6] = '{32'h0, 32'h3, 32'h1, 32'h7FFFFFFF, 32'hF0F0F0F0, 32'h80000001};
  logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFD, 16'h1234};
  int rFns [17] = '{'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h27, 'h2A, 'h2B,
                    'h00, 'h02, 'h03, 'h04, 'h06, 'h07, 'h3F};
  int iOps [8] = '{'h08, 'h09, 'h0A, 'h0B, 'h0C, 'h0D, 'h0E, 'h0F};

  initial begin
    logic [31:0] v, pcHeld, regHeld;
    logic [32:0] m;
    int nz;

    // R1: state after reset
    repeat (3) @(negedge clk);
    chk("R1 pc after reset", pcOut, 32'd0);

    // R4 R5 R6 R7 R8 R14: sweep every funct over operand pairs
    foreach (rFns[f]) begin
      for (int p = 0; p < 6; p++) begin
        int sh = (p * 7 + 3) % 32;
        setReg(1, opsA[p], 0);
        setReg(2, opsB[p], 2);
        setReg(3, 32'hA5A5A5A5, 4);
        prog[6] = encR(1, 2, 3, sh, rFns[f]);
        progLen = 7;
        runProg(7);
        m = modelR(rFns[f], opsA[p], opsB[p], sh);
        getReg(3, v);
        if (m[32]) begin
          case (rFns[f])
            'h20, 'h21, 'h22, 'h23: chk("R4 add/sub", v, m[31:0]);
            'h24, 'h25, 'h26, 'h27: chk("R5 logical", v, m[31:0]);
            'h2A, 'h2B:             chk("R6 compare", v, m[31:0]);
            'h00, 'h02, 'h03:       chk("R7 const shift", v, m[31:0]);
            default:                chk("R8 var shift", v, m[31:0]);
          endcase
        end else begin
          chk("R14 unknown funct no write", v, 32'hA5A5A5A5);
        end
        chk("R2 pc after seven steps", pcOut, 32'd28);
      end
    end

    // R9 R10 R11: sweep immediate opcodes
    foreach (iOps[o]) begin
      for (int p = 0; p < 6; p++) begin
        setReg(1, opsA[(p + 2) % 6], 0);
        prog[2] = encI(iOps[o], 1, 2, imms[p]);
        progLen = 3;
        runProg(3);
        getReg(2, v);
        if (iOps[o] <= 'h0B)      chk("R9 sign-extended imm", v, modelI(iOps[o], opsA[(p + 2) % 6], imms[p]));
        else if (iOps[o] != 'h0F) chk("R10 zero-extended imm", v, modelI(iOps[o], opsA[(p + 2) % 6], imms[p]));
        else                      chk("R11 upper imm", v, modelI(iOps[o], opsA[(p + 2) % 6], imms[p]));
      end
    end

    // R12: writes to register 0 are discarded
    prog[0] = encI('h08, 0, 0, 16'h0007);
    prog[1] = encR(0, 0, 0, 0, 'h27);
    prog[2] = encR(0, 0, 3, 0, 'h27);
    progLen = 3;
    runProg(3);
    getReg(0, v);
    chk("R12 reg0 reads zero", v, 32'd0);
    getReg(3, v);
    chk("R12 nor of reg0 pair", v, 32'hFFFFFFFF);

    // R13: jump skips an instruction and loops in place
    prog[0] = encI('h08, 0, 1, 16'd5);
    prog[1] = {6'h02, 26'd3};
    prog[2] = encI('h08, 1, 1, 16'd100);
    prog[3] = encI('h08, 1, 1, 16'd1);
    prog[4] = {6'h02, 26'd4};
    progLen = 5;
    runProg(10);
    getReg(1, v);
    chk("R13 skipped word not executed", v, 32'd6);
    chk("R13 jump to self", pcOut, 32'd16);

    // R14: unknown opcode changes no register
    setReg(1, 32'h0BADF00D, 0);
    prog[2] = encI('h3F, 2, 1, 16'h1111);
    prog[3] = encI('h05, 1, 1, 16'h2222);
    progLen = 4;
    runProg(4);
    getReg(1, v);
    chk("R14 unknown opcode no write", v, 32'h0BADF00D);
    chk("R14 pc advanced", pcOut, 32'd16);

    // R3: halt holds state while the program store is rewritten
    pcHeld = pcOut;
    getReg(1, regHeld);
    prog[0] = encI('h08, 0, 1, 16'h0042);
    progLen = 4;
    for (int i = 0; i < 4; i++) prog[i] = prog[0];
    loadProg();
    repeat (5) @(negedge clk);
    chk("R3 pc held", pcOut, pcHeld);
    getReg(1, v);
    chk("R3 reg held", v, regHeld);

    // R1: reset clears registers after a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pc cleared", pcOut, 32'd0);
    nz = 0;
    for (int r = 0; r < 32; r++) begin
      getReg(r, v);
      if (v != 0) nz++;
    end
    chk("R1 nonzero registers", 32'(nz), 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule